// File: doc/BRIEF.md
# Diagnostic Bus Frame Transmitter

This block sends one diagnostic frame on a shared single-wire serial bus. A caller gives a byte count and a start pulse, then streams the content bytes (the mode byte first, then its data) over a valid/ready handshake. The block puts a node address byte and a biased length byte in front of the content and a checksum byte behind it. It shifts the whole frame out as asynchronous serial characters.

Around the frame the block sequences the bus hardware. It enables the transmitter, waits a settle delay and only then turns on the bus driver. After the checksum it waits until the last stop bit has fully left the shift register, releases the driver, waits a second guard delay and disables the transmitter. A single-cycle done pulse then marks the end of the frame. A count that cannot be framed is refused with an error pulse and nothing is sent.

Top module: `diag_frame_tx`

## Requirements
- R1: Bytes are sent in the order address, length, content bytes in arrival order, checksum. The address is 0xF4 when NODE_ALT is 0 and 0xE4 when NODE_ALT is 1.
- R2: The length byte is the content count plus 0x55.
- R3: The checksum byte is the two's-complement negation of the 8-bit sum of all earlier frame bytes, so all frame bytes sum to 0 modulo 256.
- R4: Each byte goes out as a start bit (0), eight data bits with the LSB first, and one stop bit (1). Each bit lasts CLK_DIV clock cycles. Consecutive bytes start 10*CLK_DIV+1 cycles apart, and the line is 1 whenever the bus driver is off.
- R5: tx_en_o rises in the cycle after an accepted start. drv_en_o rises GUARD_CYCLES cycles after that, and the first start bit begins one cycle after drv_en_o rises.
- R6: drv_en_o stays high until the checksum's stop bit is complete. It falls 10*CLK_DIV+1 cycles after the checksum's start bit begins.
- R7: GUARD_CYCLES cycles after drv_en_o falls, tx_en_o and busy_o fall in the same cycle as a one-cycle done_o pulse.
- R8: A content byte is taken only in a cycle with pay_valid_i and pay_ready_o both high. While the source stalls, the frame still completes with the correct bytes.
- R9: A start pulse while busy_o is high has no effect on the frame in progress.
- R10: A count of 0 or above 0xAA gives a one-cycle err_o pulse in the cycle after start. Nothing is sent: tx_en_o, drv_en_o and busy_o stay low.
- R11: During and after reset, txd_o is 1 and tx_en_o, drv_en_o, busy_o, done_o, err_o and pay_ready_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a frame (sampled while idle) |
| count_i | input | 8 | Number of content bytes (mode plus data) |
| pay_data_i | input | 8 | Content byte |
| pay_valid_i | input | 1 | Content byte valid |
| pay_ready_o | output | 1 | Block takes a content byte this cycle |
| txd_o | output | 1 | Serial line, idle high |
| drv_en_o | output | 1 | Bus driver enable |
| tx_en_o | output | 1 | Transmitter enable |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| err_o | output | 1 | One-cycle pulse when a count is refused |

## Verification
The bench builds the block with CLK_DIV = 4 and GUARD_CYCLES = 6. It runs a second copy with NODE_ALT = 1 alongside the first. The short bit time keeps even a full 0xAA-byte frame, whose length byte is 0xFF, well inside the run time. The short guard makes the two turnaround windows short enough to compare every cycle against a timeline the bench computes. The alternate copy exposes the second address value and its effect on the checksum.

// File: rtl/diag_frame_pkg.sv
package diag_frame_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ADDR_MAIN = 8'hF4;
  localparam logic [BYTE_W-1:0] ADDR_ALT  = 8'hE4;
  localparam logic [BYTE_W-1:0] LEN_BIAS  = 8'h55;
  localparam logic [BYTE_W-1:0] MAX_COUNT = 8'hFF - LEN_BIAS;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_ADDR, ST_LEN, ST_BODY, ST_SUM, ST_DRAIN, ST_HOLD
  } seq_state_t;
endpackage

// File: rtl/diag_tx_shifter.sv
module diag_tx_shifter #(
  parameter int CLK_DIV = 12207
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       txd_o,
  output logic       busy_o
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int BITS  = 10;
  localparam int BIT_W = $clog2(BITS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);

  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic [8:0]       sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_o  <= 1'b1;
      busy_o <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      sr_q   <= '1;
    end else if (load_i && !busy_o) begin
      txd_o  <= 1'b0;
      busy_o <= 1'b1;
      div_q  <= '0;
      bit_q  <= '0;
      sr_q   <= {1'b1, data_i};
    end else if (busy_o) begin
      if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (bit_q == BIT_LAST) begin
          busy_o <= 1'b0;
        end else begin
          txd_o <= sr_q[0];
          sr_q  <= {1'b1, sr_q[8:1]};
          bit_q <= bit_q + 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R4: a byte is loaded only into an empty shift register
  assert_load_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !busy_o);
  // R4: the stop bit is still on the line when the register empties
  assert_stop_high_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> txd_o);
endmodule

// File: rtl/diag_guard_timer.sv
module diag_guard_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (cnt_q != CNT_LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == CNT_LAST);

  // R5: the count never passes the guard length
  assert_guard_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_LAST);
endmodule

// File: rtl/diag_frame_seq.sv
module diag_frame_seq
  import diag_frame_pkg::*;
#(
  parameter bit NODE_ALT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [7:0] count_i,
  input  logic [7:0] pay_data_i,
  input  logic       pay_valid_i,
  output logic       pay_ready_o,
  output logic       sh_load_o,
  output logic [7:0] sh_data_o,
  input  logic       sh_busy_i,
  output logic       guard_run_o,
  input  logic       guard_expire_i,
  output logic       drv_en_o,
  output logic       tx_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  localparam logic [7:0] NODE_ADDR = NODE_ALT ? ADDR_ALT : ADDR_MAIN;

  seq_state_t state_q;
  logic [7:0] sum_q;
  logic [7:0] rem_q;
  logic [7:0] len_q;
  logic       count_ok;

  assign count_ok    = (count_i != 8'd0) && (count_i <= MAX_COUNT);
  assign guard_run_o = (state_q == ST_SETTLE) || (state_q == ST_HOLD);
  assign pay_ready_o = (state_q == ST_BODY) && !sh_busy_i;

  always_comb begin
    sh_load_o = 1'b0;
    sh_data_o = 8'h00;
    case (state_q)
      ST_ADDR: begin sh_load_o = !sh_busy_i; sh_data_o = NODE_ADDR; end
      ST_LEN:  begin sh_load_o = !sh_busy_i; sh_data_o = len_q; end
      ST_BODY: begin sh_load_o = !sh_busy_i && pay_valid_i; sh_data_o = pay_data_i; end
      ST_SUM:  begin sh_load_o = !sh_busy_i; sh_data_o = 8'h00 - sum_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      sum_q    <= '0;
      rem_q    <= '0;
      len_q    <= '0;
      drv_en_o <= 1'b0;
      tx_en_o  <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          if (count_ok) begin
            state_q <= ST_SETTLE;
            tx_en_o <= 1'b1;
            busy_o  <= 1'b1;
            rem_q   <= count_i;
            len_q   <= count_i + LEN_BIAS;
            sum_q   <= '0;
          end else begin
            err_o <= 1'b1;
          end
        end
        ST_SETTLE: if (guard_expire_i) begin
          drv_en_o <= 1'b1;
          state_q  <= ST_ADDR;
        end
        ST_ADDR: if (sh_load_o) state_q <= ST_LEN;
        ST_LEN:  if (sh_load_o) state_q <= ST_BODY;
        ST_BODY: if (sh_load_o) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == 8'd1) state_q <= ST_SUM;
        end
        ST_SUM:   if (sh_load_o) state_q <= ST_DRAIN;
        ST_DRAIN: if (!sh_busy_i) begin
          drv_en_o <= 1'b0;
          state_q  <= ST_HOLD;
        end
        ST_HOLD: if (guard_expire_i) begin
          tx_en_o <= 1'b0;
          busy_o  <= 1'b0;
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (sh_load_o) sum_q <= sum_q + sh_data_o;
    end
  end

  // R5: the driver is only on inside the transmitter window
  assert_drv_inside_txen_R5: assert property (@(posedge clk) disable iff (rst)
    drv_en_o |-> tx_en_o);
  // R6: the driver is released only once the shift register is empty
  assert_drv_release_empty_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_en_o) |-> !sh_busy_i);
  // R7: done lasts one cycle and busy ends only with it
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_busy_ends_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  // R8: content is only requested during a frame
  assert_ready_in_frame_R8: assert property (@(posedge clk) disable iff (rst)
    pay_ready_o |-> (busy_o && drv_en_o));
  // R10: a refused count starts nothing
  assert_err_idle_R10: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!tx_en_o && !busy_o));
endmodule

// File: rtl/diag_frame_tx.sv
module diag_frame_tx #(
  parameter int CLK_DIV      = 12207,
  parameter int GUARD_CYCLES = 2000,
  parameter bit NODE_ALT     = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [7:0] count_i,
  input  logic [7:0] pay_data_i,
  input  logic       pay_valid_i,
  output logic       pay_ready_o,
  output logic       txd_o,
  output logic       drv_en_o,
  output logic       tx_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);
  logic       sh_load;
  logic [7:0] sh_data;
  logic       sh_busy;
  logic       guard_run;
  logic       guard_expire;

  diag_frame_seq #(.NODE_ALT(NODE_ALT)) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .count_i(count_i),
    .pay_data_i(pay_data_i), .pay_valid_i(pay_valid_i), .pay_ready_o(pay_ready_o),
    .sh_load_o(sh_load), .sh_data_o(sh_data), .sh_busy_i(sh_busy),
    .guard_run_o(guard_run), .guard_expire_i(guard_expire),
    .drv_en_o(drv_en_o), .tx_en_o(tx_en_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o)
  );

  diag_tx_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .load_i(sh_load), .data_i(sh_data),
    .txd_o(txd_o), .busy_o(sh_busy)
  );

  diag_guard_timer #(.CYCLES(GUARD_CYCLES)) u_guard (
    .clk(clk), .rst(rst), .run_i(guard_run), .expire_o(guard_expire)
  );

  // R4: the line rests high whenever the driver is off
  assert_line_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !drv_en_o |-> txd_o);
endmodule

// File: tb/test_diag_frame_tx.sv
module test_diag_frame_tx;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int D = 4;
  localparam int G = 6;
  localparam int P = 10 * D + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, start, pay_valid;
  logic [7:0] count, pay_data;
  logic       ready, txd, drv, txen, busy, done, err;
  logic       ready_a, txd_a, drv_a, txen_a, busy_a, done_a, err_a;

  diag_frame_tx #(.CLK_DIV(D), .GUARD_CYCLES(G), .NODE_ALT(1'b0)) i_diag_frame_tx (
    .clk(clk), .rst(rst), .start_i(start), .count_i(count), .pay_data_i(pay_data),
    .pay_valid_i(pay_valid), .pay_ready_o(ready), .txd_o(txd), .drv_en_o(drv),
    .tx_en_o(txen), .busy_o(busy), .done_o(done), .err_o(err));

  diag_frame_tx #(.CLK_DIV(D), .GUARD_CYCLES(G), .NODE_ALT(1'b1)) i_diag_frame_tx_alt (
    .clk(clk), .rst(rst), .start_i(start), .count_i(count), .pay_data_i(pay_data),
    .pay_valid_i(pay_valid), .pay_ready_o(ready_a), .txd_o(txd_a), .drv_en_o(drv_a),
    .tx_en_o(txen_a), .busy_o(busy_a), .done_o(done_a), .err_o(err_a));

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] fr[$];
  logic [7:0] fr_alt[$];
  logic [7:0] pq[$];
  logic [7:0] rxq[$];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Frame image built from the requirements
  task automatic build(int cnt, int seed);
    logic [7:0] s, sa, b;
    fr.delete(); fr_alt.delete(); pq.delete();
    fr.push_back(8'hF4); fr_alt.push_back(8'hE4);
    b = 8'(cnt + 8'h55);
    fr.push_back(b); fr_alt.push_back(b);
    for (int i = 0; i < cnt; i++) begin
      b = 8'((i * 37 + seed * 11 + 3) & 8'hFF);
      pq.push_back(b); fr.push_back(b); fr_alt.push_back(b);
    end
    s = 0; sa = 0;
    foreach (fr[i]) s = s + fr[i];
    foreach (fr_alt[i]) sa = sa + fr_alt[i];
    fr.push_back(8'h00 - s); fr_alt.push_back(8'h00 - sa);
  endtask

  function automatic logic model_txd(int k, bit alt);
    int j, i, r, b;
    logic [7:0] v;
    if (k < G + 1) return 1'b1;
    j = k - G - 1; i = j / P; r = j % P;
    if (i >= fr.size()) return 1'b1;
    v = alt ? fr_alt[i] : fr[i];
    if (r >= 10 * D) return 1'b1;
    b = r / D;
    if (b == 0) return 1'b0;
    if (b == 9) return 1'b1;
    return v[b-1];
  endfunction

  // Serial decoder on the main line
  initial begin
    logic [7:0] v;
    forever begin
      @(posedge clk); #1;
      if (txd === 1'b0 && drv === 1'b1) begin
        repeat (D / 2) @(posedge clk);
        for (int b = 0; b < 8; b++) begin
          repeat (D) @(posedge clk); #1;
          v[b] = txd;
        end
        repeat (D) @(posedge clk); #1;
        chk("R4 stop bit", int'(txd), 1);
        rxq.push_back(v);
      end
    end
  end

  task automatic cmp_cycle(int k, int n);
    int tend = 2 * G + 1 + n * P;
    chk("R5/R7 tx_en", int'(txen), int'(k < tend));
    chk("R7 busy", int'(busy), int'(k < tend));
    chk("R5/R6 drv_en", int'(drv), int'(k >= G && k < G + 1 + n * P));
    chk("R7 done", int'(done), int'(k == tend));
    chk("R4 txd timeline", int'(txd), int'(model_txd(k, 1'b0)));
    chk("R1 alt txd timeline", int'(txd_a), int'(model_txd(k, 1'b1)));
  endtask

  task automatic check_rx(string tag);
    repeat (4) @(posedge clk);
    chk({tag, " R1 byte count"}, rxq.size(), fr.size());
    if (rxq.size() == fr.size()) begin
      logic [7:0] s = 0;
      chk("R1 address", rxq[0], 8'hF4);
      chk("R2 length", rxq[1], fr[1]);
      for (int i = 2; i < fr.size() - 1; i++) chk("R1 content order", rxq[i], fr[i]);
      chk("R3 checksum", rxq[fr.size()-1], fr[fr.size()-1]);
      foreach (rxq[i]) s = s + rxq[i];
      chk("R3 zero sum", s, 0);
    end
  endtask

  task automatic run_frame(int cnt, int seed, bit intrude);
    int n, tend;
    bit xfer;
    build(cnt, seed);
    rxq.delete();
    n = fr.size();
    tend = 2 * G + 1 + n * P;
    @(negedge clk); start = 1; count = 8'(cnt);
    @(posedge clk); #1; start = 0;
    cmp_cycle(0, n);
    for (int k = 1; k <= tend + 2; k++) begin
      @(negedge clk);
      start = (intrude && (k == 30 || k == tend - 2));   // R9
      count = 8'd3;
      pay_valid = (pq.size() > 0);
      pay_data = (pq.size() > 0) ? pq[0] : 8'h00;
      xfer = pay_valid && ready;
      @(posedge clk); #1;
      if (xfer) void'(pq.pop_front());
      cmp_cycle(k, n);
    end
    @(negedge clk); start = 0; pay_valid = 0;
    check_rx(intrude ? "R9" : "frame");
  endtask

  task automatic run_stall(int cnt, int seed);
    int k;
    bit xfer, seen;
    build(cnt, seed);
    rxq.delete();
    @(negedge clk); start = 1; count = 8'(cnt);
    @(posedge clk); #1; start = 0;
    seen = 0; k = 0;
    while (!seen && k < 20000) begin
      k++;
      @(negedge clk);
      pay_valid = (pq.size() > 0) && !((k % 97) < 60);
      pay_data = (pq.size() > 0) ? pq[0] : 8'h00;
      xfer = pay_valid && ready;
      @(posedge clk); #1;
      if (xfer) void'(pq.pop_front());
      if (done) seen = 1;
      if (busy && !drv && k > G + 1 && !seen) begin
        if (rxq.size() < fr.size()) chk("R8 driver held during stall", int'(drv), 1);
      end
    end
    @(negedge clk); pay_valid = 0;
    chk("R8 frame completes", int'(seen), 1);
    chk("R8 all content taken", pq.size(), 0);
    check_rx("R8");
  endtask

  task automatic run_reject(int cnt);
    int r = rxq.size();
    @(negedge clk); start = 1; count = 8'(cnt);
    @(posedge clk); #1; start = 0;
    chk("R10 err pulse", int'(err), 1);
    chk("R10 busy low", int'(busy), 0);
    for (int k = 1; k < 2 * G + 10; k++) begin
      @(posedge clk); #1;
      chk("R10 err single", int'(err), 0);
      chk("R10 tx_en low", int'(txen), 0);
      chk("R10 drv low", int'(drv), 0);
      chk("R10 line high", int'(txd), 1);
    end
    chk("R10 nothing sent", rxq.size(), r);
  endtask

  initial begin
    #900000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; start = 0; count = 0; pay_data = 0; pay_valid = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 reset txd", int'(txd), 1);
    chk("R11 reset tx_en", int'(txen), 0);
    chk("R11 reset drv", int'(drv), 0);
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset ready", int'(ready), 0);
    @(negedge clk); rst = 0;
    repeat (3) @(posedge clk); #1;
    chk("R11 idle done", int'(done), 0);
    chk("R11 idle err", int'(err), 0);
    chk("R11 idle txd", int'(txd), 1);

    run_frame(1, 1, 0);
    run_frame(5, 2, 0);
    run_frame(3, 7, 1);
    run_reject(0);
    run_reject(8'hAB);
    run_frame(8'hAA, 4, 0);
    run_stall(6, 9);
    run_frame(2, 5, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule